// File: doc/BRIEF.md
# Ring Signal Validator and Melody Gate

This block sits behind the ring detector of a telephone while the handset is on-hook. It takes the ring-detect pulse train after the Schmitt trigger, measures the time from each rising edge to the next, and decides whether the ringing frequency is inside the accepted band of 13 Hz to 70 Hz. Validity must then be held continuously for a qualification window of about 75 ms. After that, the block enables a two-tone melody that alternates between 1250 Hz and 1600 Hz. The output is a pull-low enable for an open-drain melody pin.

Periods are counted in ticks of a prescaled timebase. With the default parameters and a 3.579545 MHz clock, one tick is about 0.1 ms. The upper band limit is 769 ticks (13 Hz), the lower limit is 143 ticks (70 Hz), the qualification window is 750 ticks, and each tone lasts 250 ticks before the other one replaces it. When validity is lost, the melody continues for a hold window of 1000 ticks. This lets it ride through short gaps in the ringing. If the handset goes off-hook, both outputs drop in the same cycle and all internal state is cleared.

Top module: `ring_gate_top`

## Requirements
- R1: While reset is high, and on the first cycles after it, `ring_ok` and `mel_pull` are 0.
- R2: The first rising edge after an idle spell only arms the meter. An edge interval of PER_MIN to PER_MAX ticks, both inclusive, makes the signal valid (`ring_ok`=1). A shorter interval makes it invalid.
- R3: If an armed meter sees no new rising edge within PER_MAX+1 ticks, the signal becomes invalid. The meter is then disarmed.
- R4: `mel_pull` can start toggling only after `ring_ok` has stayed 1 for QUAL_TICKS ticks without an invalid event. An invalid event during that window restarts qualification from idle.
- R5: The melody starts with a square wave whose half-period is HALF_A clocks. The tone switches between HALF_A and HALF_B every SWAP_TICKS ticks. Each switch restarts the half-period count.
- R6: After validity is lost while the melody plays, the melody continues for HOLD_TICKS ticks. A valid edge during that time returns it to normal play.
- R7: While `on_hook` is 0, both outputs are 0 in that same cycle. All state is cleared, so on-hook operation restarts from idle.
- R8: `mel_pull`=1 means drive the open-drain pin low. It can be 1 only while the melody is playing or holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| on_hook | input | 1 | 1 while the handset is on-hook; 0 disables the block at once |
| ring_in | input | 1 | Schmitt-triggered ring-detect pulse train (asynchronous) |
| ring_ok | output | 1 | Ring signal currently judged valid |
| mel_pull | output | 1 | Pull-low enable for the open-drain melody output |

## Verification
The properties assume that `ring_in` is only seen through the internal three-stage synchroniser. They also assume that reset is held for at least two clocks, so every `$past` value after reset comes from a reset state. The bench drives `ring_in` and `on_hook` only on falling clock edges, holds reset for five cycles, and uses square pulse trains whose periods lie clearly inside the band, below it, or above it. It also includes single pulses, a high level that never changes, and a short gap. A per-clock behavioural model predicts both outputs exactly, tick phase included.

// File: rtl/ring_gate_pkg.sv
package ring_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_PLAY = 2'd2,
        ST_HOLD = 2'd3
    } ring_state_e;

    typedef struct packed {
        logic good;
        logic bad;
    } ring_evt_t;

    function automatic int cnt_w(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic melody_on(input ring_state_e s);
        return (s == ST_PLAY) || (s == ST_HOLD);
    endfunction

    function automatic logic signal_ok(input ring_state_e s);
        return (s == ST_QUAL) || (s == ST_PLAY);
    endfunction

endpackage

// File: rtl/rg_tick_gen.sv
module rg_tick_gen
    import ring_gate_pkg::*;
#(
    parameter int TICK_DIV = 358
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = cnt_w(TICK_DIV - 1);

    logic [TW-1:0] pc;

    assign tick = run && (pc == TW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/rg_period_meter.sv
module rg_period_meter
    import ring_gate_pkg::*;
#(
    parameter int PER_MIN = 143,
    parameter int PER_MAX = 769
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       ring_in,
    input  logic                       tick,
    output ring_evt_t                  evt,
    output logic                       armed,
    output logic [cnt_w(PER_MAX)-1:0]  per
);
    localparam int PW = cnt_w(PER_MAX);

    logic [2:0] sh;
    logic       rise;
    logic       in_band;
    logic       stale;

    assign rise    = sh[1] && !sh[2];
    assign in_band = (per >= PW'(PER_MIN)) && (per <= PW'(PER_MAX));
    assign stale   = !rise && tick && armed && (per == PW'(PER_MAX));

    always_comb begin
        evt.good = rise && armed && in_band;
        evt.bad  = (rise && armed && !in_band) || stale;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sh    <= '0;
            armed <= 1'b0;
            per   <= '0;
        end else begin
            sh <= {sh[1:0], ring_in};
            if (rise) begin
                per   <= '0;
                armed <= 1'b1;
            end else if (stale) begin
                per   <= '0;
                armed <= 1'b0;
            end else if (tick && armed) begin
                per <= per + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rg_tone_gen.sv
module rg_tone_gen
    import ring_gate_pkg::*;
#(
    parameter int HALF_A     = 1432,
    parameter int HALF_B     = 1119,
    parameter int SWAP_TICKS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic wave,
    output logic sel
);
    localparam int HW = cnt_w(max2(HALF_A, HALF_B));
    localparam int SW = cnt_w(SWAP_TICKS);

    logic [HW-1:0] hc;
    logic [SW-1:0] sc;
    logic [HW-1:0] half_last;
    logic          swap;

    assign half_last = sel ? HW'(HALF_B - 1) : HW'(HALF_A - 1);
    assign swap      = tick && (sc == SW'(SWAP_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hc   <= '0;
            sc   <= '0;
            sel  <= 1'b0;
            wave <= 1'b0;
        end else begin
            if (swap) begin
                sc <= '0;
            end else if (tick) begin
                sc <= sc + 1'b1;
            end
            if (swap) begin
                sel <= !sel;
                hc  <= '0;
            end else if (hc == half_last) begin
                hc   <= '0;
                wave <= !wave;
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_gate_top.sv
module ring_gate_top
    import ring_gate_pkg::*;
#(
    parameter int TICK_DIV   = 358,
    parameter int PER_MIN    = 143,
    parameter int PER_MAX    = 769,
    parameter int QUAL_TICKS = 750,
    parameter int HOLD_TICKS = 1000,
    parameter int SWAP_TICKS = 250,
    parameter int HALF_A     = 1432,
    parameter int HALF_B     = 1119
) (
    input  logic clk,
    input  logic rst,
    input  logic on_hook,
    input  logic ring_in,
    output logic ring_ok,
    output logic mel_pull
);
    localparam int QW = cnt_w(QUAL_TICKS);
    localparam int HW = cnt_w(HOLD_TICKS);
    localparam int PW = cnt_w(PER_MAX);

    logic          tick;
    ring_evt_t     evt;
    logic          armed;
    logic [PW-1:0] per;
    ring_state_e   st;
    logic [QW-1:0] qcnt;
    logic [HW-1:0] hcnt;
    logic          tone_en;
    logic          wave;
    logic          tone_sel;

    rg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (on_hook),
        .tick(tick)
    );

    rg_period_meter #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .run    (on_hook),
        .ring_in(ring_in),
        .tick   (tick),
        .evt    (evt),
        .armed  (armed),
        .per    (per)
    );

    assign tone_en = on_hook && melody_on(st);

    rg_tone_gen #(.HALF_A(HALF_A), .HALF_B(HALF_B), .SWAP_TICKS(SWAP_TICKS)) u_tone (
        .clk (clk),
        .rst (rst),
        .en  (tone_en),
        .tick(tick),
        .wave(wave),
        .sel (tone_sel)
    );

    always_ff @(posedge clk) begin
        if (rst || !on_hook) begin
            st   <= ST_IDLE;
            qcnt <= '0;
            hcnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (evt.good) begin
                        st   <= ST_QUAL;
                        qcnt <= '0;
                    end
                end
                ST_QUAL: begin
                    if (evt.bad) begin
                        st <= ST_IDLE;
                    end else if (tick) begin
                        if (qcnt == QW'(QUAL_TICKS - 1)) begin
                            st   <= ST_PLAY;
                            qcnt <= '0;
                        end else begin
                            qcnt <= qcnt + 1'b1;
                        end
                    end
                end
                ST_PLAY: begin
                    if (evt.bad) begin
                        st   <= ST_HOLD;
                        hcnt <= '0;
                    end
                end
                ST_HOLD: begin
                    if (evt.good) begin
                        st <= ST_PLAY;
                    end else if (tick) begin
                        if (hcnt == HW'(HOLD_TICKS - 1)) begin
                            st   <= ST_IDLE;
                            hcnt <= '0;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ring_ok  = on_hook && signal_ok(st);
    assign mel_pull = on_hook && melody_on(st) && wave;

endmodule

// File: rtl/ring_gate_chk.sv
module ring_gate_chk
    import ring_gate_pkg::*;
#(
    parameter int QUAL_TICKS = 750,
    parameter int HOLD_TICKS = 1000,
    parameter int PER_MAX    = 769,
    parameter int QW         = 10,
    parameter int HW         = 10,
    parameter int PW         = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          on_hook,
    input logic          ring_ok,
    input logic          mel_pull,
    input ring_state_e   st,
    input logic          tick,
    input logic          evt_good,
    input logic          armed,
    input logic [QW-1:0] qcnt,
    input logic [HW-1:0] hcnt,
    input logic [PW-1:0] per,
    input logic          tone_en,
    input logic          tone_sel
);
    p_offhook_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !on_hook |-> (!ring_ok && !mel_pull));

    p_offhook_clears_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!on_hook) |-> (st == ST_IDLE));

    p_pull_only_melody_r8: assert property (@(posedge clk) disable iff (rst)
        mel_pull |-> ((st == ST_PLAY) || (st == ST_HOLD)));

    p_qual_done_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PLAY && $past(st) == ST_QUAL)
            |-> ($past(tick) && $past(qcnt) == QW'(QUAL_TICKS - 1)));

    p_valid_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_QUAL && $past(st) == ST_IDLE) |-> $past(evt_good));

    p_period_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        per <= PW'(PER_MAX));

    p_disarmed_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (per == '0));

    p_swap_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(tone_en) && tone_sel != $past(tone_sel)) |-> $past(tick));

    p_hold_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st) == ST_HOLD)
            |-> (!$past(on_hook) || ($past(tick) && $past(hcnt) == HW'(HOLD_TICKS - 1))));
endmodule

bind ring_gate_top ring_gate_chk #(
    .QUAL_TICKS(QUAL_TICKS),
    .HOLD_TICKS(HOLD_TICKS),
    .PER_MAX   (PER_MAX),
    .QW        (QW),
    .HW        (HW),
    .PW        (PW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .on_hook (on_hook),
    .ring_ok (ring_ok),
    .mel_pull(mel_pull),
    .st      (st),
    .tick    (tick),
    .evt_good(evt.good),
    .armed   (armed),
    .qcnt    (qcnt),
    .hcnt    (hcnt),
    .per     (per),
    .tone_en (tone_en),
    .tone_sel(tone_sel)
);

// File: tb/ring_gate_top_tb.sv
module ring_gate_top_tb;
    localparam int TD   = 2;
    localparam int PMIN = 5;
    localparam int PMAX = 20;
    localparam int QUAL = 40;
    localparam int HOLD = 30;
    localparam int SWAP = 10;
    localparam int HA   = 4;
    localparam int HB   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hook = 1'b0;
    logic rd = 1'b0;
    logic ring_ok;
    logic mel_pull;

    always #10 clk = ~clk;

    ring_gate_top #(
        .TICK_DIV(TD), .PER_MIN(PMIN), .PER_MAX(PMAX), .QUAL_TICKS(QUAL),
        .HOLD_TICKS(HOLD), .SWAP_TICKS(SWAP), .HALF_A(HA), .HALF_B(HB)
    ) u_dut (
        .clk(clk), .rst(rst), .on_hook(hook), .ring_in(rd),
        .ring_ok(ring_ok), .mel_pull(mel_pull)
    );

    int total = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_s1, m_s2, m_s3, m_pc, m_per, m_arm, m_st, m_q, m_h, m_sc, m_sel, m_hc, m_wave;
    int b_rise, b_tick, b_good, b_bad, b_men, b_half, b_swap;

    always @(posedge clk) begin
        if (rst || !hook) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pc = 0; m_per = 0; m_arm = 0;
            m_st = 0; m_q = 0; m_h = 0; m_sc = 0; m_sel = 0; m_hc = 0; m_wave = 0;
        end else begin
            b_rise = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            b_tick = (m_pc == TD - 1) ? 1 : 0;
            b_good = 0; b_bad = 0;
            if (b_rise == 1) begin
                if (m_arm == 1) begin
                    if (m_per >= PMIN && m_per <= PMAX) b_good = 1; else b_bad = 1;
                end
            end else if (b_tick == 1 && m_arm == 1 && m_per == PMAX) begin
                b_bad = 1;
            end
            b_men = (m_st == 2 || m_st == 3) ? 1 : 0;
            // melody
            if (b_men == 0) begin
                m_sc = 0; m_sel = 0; m_hc = 0; m_wave = 0;
            end else begin
                b_half = (m_sel == 1) ? HB : HA;
                b_swap = (b_tick == 1 && m_sc == SWAP - 1) ? 1 : 0;
                if (b_swap == 1) m_sc = 0; else if (b_tick == 1) m_sc++;
                if (b_swap == 1) begin m_sel = 1 - m_sel; m_hc = 0; end
                else if (m_hc == b_half - 1) begin m_hc = 0; m_wave = 1 - m_wave; end
                else m_hc++;
            end
            // sequencing
            case (m_st)
                0: if (b_good == 1) begin m_st = 1; m_q = 0; end
                1: if (b_bad == 1) m_st = 0;
                   else if (b_tick == 1) begin
                       if (m_q == QUAL - 1) begin m_st = 2; m_q = 0; end else m_q++;
                   end
                2: if (b_bad == 1) begin m_st = 3; m_h = 0; end
                default: if (b_good == 1) m_st = 2;
                   else if (b_tick == 1) begin
                       if (m_h == HOLD - 1) begin m_st = 0; m_h = 0; end else m_h++;
                   end
            endcase
            // period meter
            if (b_rise == 1) begin m_per = 0; m_arm = 1; end
            else if (b_tick == 1 && m_arm == 1 && m_per == PMAX) begin m_per = 0; m_arm = 0; end
            else if (b_tick == 1 && m_arm == 1) m_per++;
            m_pc = (b_tick == 1) ? 0 : m_pc + 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = rd;
        end
    end

    // observation bookkeeping
    int runlen = 0;
    bit seen_a = 0, seen_b = 0, seen_ok = 0, seen_pull = 0;
    int ok_rise_cyc = -1, first_pull_cyc = -1, cyc = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare;
        int e_ok, e_pull;
        e_ok   = (hook && (m_st == 1 || m_st == 2)) ? 1 : 0;
        e_pull = (hook && (m_st == 2 || m_st == 3) && m_wave == 1) ? 1 : 0;
        check(cur_req, int'(ring_ok), e_ok, "ring_ok vs model");
        check(cur_req, int'(mel_pull), e_pull, "mel_pull vs model");
        if (ring_ok) seen_ok = 1;
        if (mel_pull) seen_pull = 1;
        if (ring_ok && ok_rise_cyc < 0) ok_rise_cyc = cyc;
        if (mel_pull && first_pull_cyc < 0) first_pull_cyc = cyc;
        if (mel_pull) runlen++;
        else begin
            if (runlen == HA) seen_a = 1;
            if (runlen == HB) seen_b = 1;
            runlen = 0;
        end
    endtask

    task automatic step(input logic h, input logic r);
        @(negedge clk);
        cyc++;
        compare();
        hook = h;
        rd = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(hook, rd);
    endtask

    task automatic pulses(input int period, input int count);
        for (int i = 0; i < count; i++) begin
            for (int j = 0; j < period; j++) step(1'b1, (j < period / 2) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic clear_obs;
        seen_ok = 0; seen_pull = 0; seen_a = 0; seen_b = 0;
        ok_rise_cyc = -1; first_pull_cyc = -1; runlen = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        cur_req = "R1";
        check("R1", int'(ring_ok), 0, "ring_ok in reset");
        check("R1", int'(mel_pull), 0, "mel_pull in reset");
        rst = 1'b0;
        idle(3);
        step(1'b1, 1'b0);
        idle(5);

        // single pulse: arms only
        cur_req = "R2";
        clear_obs();
        pulses(20, 1);
        idle(10);
        check("R2", int'(seen_ok), 0, "single edge must not validate");
        idle(80);

        // valid ringing, melody with two tones
        cur_req = "R4 R5 R8";
        clear_obs();
        pulses(20, 20);
        check("R2", int'(seen_ok), 1, "in-band ringing validates");
        check("R4", int'(seen_pull), 1, "melody after qualification");
        check("R4", int'(first_pull_cyc - ok_rise_cyc >= QUAL * TD), 1, "qualification delay");
        check("R5", int'(seen_a), 1, "tone A half-period seen");
        check("R5", int'(seen_b), 1, "tone B half-period seen");

        // short gap rides through hold
        cur_req = "R6";
        clear_obs();
        for (int j = 0; j < 45; j++) step(1'b1, 1'b0);
        pulses(20, 4);
        check("R6", int'(seen_pull), 1, "melody kept through gap");

        // stop: timeout, hold, then silence
        cur_req = "R3 R6";
        for (int j = 0; j < 150; j++) step(1'b1, 1'b0);
        clear_obs();
        idle(20);
        check("R6", int'(seen_pull), 0, "melody ended after hold");
        check("R3", int'(seen_ok), 0, "no validity without edges");

        // too fast
        cur_req = "R2";
        clear_obs();
        pulses(6, 50);
        check("R2", int'(seen_ok), 0, "fast ringing rejected");
        idle(60);

        // too slow
        cur_req = "R3";
        clear_obs();
        pulses(60, 6);
        check("R3", int'(seen_ok), 0, "slow ringing rejected");

        // stuck high after valid ringing
        cur_req = "R3";
        clear_obs();
        pulses(20, 3);
        for (int j = 0; j < 60; j++) step(1'b1, 1'b1);
        check("R3", int'(ring_ok), 0, "stuck level invalidates");
        for (int j = 0; j < 20; j++) step(1'b1, 1'b0);

        // off-hook mid melody
        cur_req = "R7";
        clear_obs();
        pulses(20, 10);
        check("R7", int'(seen_pull), 1, "melody playing before off-hook");
        @(negedge clk);
        cyc++;
        compare();
        hook = 1'b0;
        #1;
        check("R7", int'(ring_ok), 0, "ring_ok same cycle off-hook");
        check("R7", int'(mel_pull), 0, "mel_pull same cycle off-hook");
        for (int j = 0; j < 40; j++) step(1'b0, (j % 20 < 10) ? 1'b1 : 1'b0);
        clear_obs();
        for (int j = 0; j < 20; j++) step(1'b1, (j % 20 < 10) ? 1'b1 : 1'b0);
        check("R7", int'(seen_ok), 0, "restart from idle after on-hook");
        idle(5);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule